// File: doc/BRIEF.md
# Control-Phase Word Decoder with Triplet Voting

This block sits behind a serial receiver's shift register and word aligner. Each parallel clock it may accept one aligned 20-bit word, along with a flag that says whether the word belongs to the video phase or the control phase. Bit 0 of the word is the first bit received. The block turns the word into registered parallel outputs: an 18-bit video bus, a 9-bit control bus, and a phase indicator.

In a control word, five of the control bits arrive three times each. The block recovers each of them by a 2-of-3 vote, so one bad copy per bit is corrected. The other four control bits are taken as single raw bits. In a video word, the 18 symbol bits pass through a separate decode stage, which is an identity mapping by default. Whichever bus belongs to the phase that is not active keeps its last value. A one-cycle flag marks every control word in which a triplet did not agree, so errors that were corrected can be counted.

Top module: `pwd_word_decoder`

## Requirements
- R1: On synchronous reset, the outputs `de_out`, `vid_out`, `ctl_out` and `vote_err` are all 0.
- R2: One cycle after a valid video word (`word_vld`=1, `word_is_video`=1), `de_out` is 1 and `vid_out` equals `word_in[19:2]`, with `vid_out[k]` taken from `word_in[k+2]`.
- R3: One cycle after a valid control word, each `ctl_out[i]` for i in 0..4 equals the majority of `word_in[3i+1]`, `word_in[3i+2]` and `word_in[3i+3]`.
- R4: One cycle after a valid control word, each `ctl_out[5+j]` for j in 0..3 equals `word_in[16+j]`, with no voting.
- R5: One cycle after a valid control word, `de_out` is 0.
- R6: A valid control word leaves `vid_out` unchanged.
- R7: A valid video word leaves `ctl_out` unchanged.
- R8: `vote_err` is 1 for exactly the cycle after a valid control word in which at least one of the five triplets has copies that differ. Otherwise it is 0, including after every video word.
- R9: A cycle with `word_vld`=0 leaves `de_out`, `vid_out` and `ctl_out` unchanged, and `vote_err` is 0 in the cycle after it.
- R10: The overhead bits have no effect on any output. These are `word_in[0]` in both phases and `word_in[1]` in video words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst | input | 1 | Synchronous reset, active high |
| word_vld | input | 1 | An aligned word is present this cycle |
| word_is_video | input | 1 | 1 means a video-phase word, 0 means a control-phase word |
| word_in | input | 20 | Aligned serial word; bit 0 is the first bit received |
| de_out | output | 1 | Phase of the last accepted word (1 = video) |
| vid_out | output | 18 | Decoded video symbols, held during the control phase |
| ctl_out | output | 9 | Recovered control bits, held during the video phase |
| vote_err | output | 1 | Pulse: the last accepted control word had a split triplet |

## Verification
Every result is due exactly one clock edge after the word that causes it. This covers the phase indicator, the bus of the active phase and the mismatch flag. The bench drives a word on a falling edge, lets one rising edge pass, and compares on the next falling edge before it drives the following word. The expected value is always the one caused by the word just driven. The bus of the inactive phase is compared against its value from the word before, and after an idle cycle all three data outputs are compared against their previous values. Any bus that changes when it should hold is therefore caught in the same cycle.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  // 2-of-3 majority of a triplet
  function automatic logic maj3(input logic [2:0] t);
    return (t[0] & t[1]) | (t[1] & t[2]) | (t[0] & t[2]);
  endfunction

  // copies of a triplet do not all agree
  function automatic logic split3(input logic [2:0] t);
    return (t != 3'b000) && (t != 3'b111);
  endfunction
endpackage

// File: rtl/pwd_field_split.sv
module pwd_field_split #(
  parameter int TRIP_N = 5,
  parameter int RAW_N  = 4,
  localparam int WORD_W = 1 + 3*TRIP_N + RAW_N,
  localparam int VID_W  = WORD_W - 2
) (
  input  logic [WORD_W-1:0]     word_i,
  output logic [TRIP_N-1:0][2:0] trip_o,
  output logic [RAW_N-1:0]      raw_o,
  output logic [VID_W-1:0]      sym_o
);
  logic ovh_unused;
  assign ovh_unused = word_i[0];

  for (genvar i = 0; i < TRIP_N; i++) begin : g_trip
    assign trip_o[i] = word_i[3*i+3 -: 3];
  end

  assign raw_o = word_i[WORD_W-1 -: RAW_N];
  assign sym_o = word_i[WORD_W-1:2];
endmodule

// File: rtl/pwd_triplet_voter.sv
module pwd_triplet_voter #(
  parameter int TRIP_N = 5
) (
  input  logic [TRIP_N-1:0][2:0] trip_i,
  output logic [TRIP_N-1:0]      voted_o,
  output logic                   any_split_o
);
  import pwd_pkg::*;
  logic [TRIP_N-1:0] split;

  for (genvar i = 0; i < TRIP_N; i++) begin : g_vote
    assign voted_o[i] = maj3(trip_i[i]);
    assign split[i]   = split3(trip_i[i]);
  end

  assign any_split_o = |split;
endmodule

// File: rtl/pwd_video_decode.sv
module pwd_video_decode #(
  parameter int VID_W = 18
) (
  input  logic [VID_W-1:0] sym_i,
  output logic [VID_W-1:0] data_o
);
  // placeholder for the symbol balance decode: identity mapping
  assign data_o = sym_i;
endmodule

// File: rtl/pwd_out_regs.sv
module pwd_out_regs #(
  parameter int VID_W = 18,
  parameter int CTL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vid_take,
  input  logic             ctl_take,
  input  logic             split_seen,
  input  logic [VID_W-1:0] vid_next,
  input  logic [CTL_W-1:0] ctl_next,
  output logic             de_q,
  output logic [VID_W-1:0] vid_q,
  output logic [CTL_W-1:0] ctl_q,
  output logic             err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      de_q  <= 1'b0;
      vid_q <= '0;
      ctl_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= ctl_take & split_seen;
      if (vid_take) begin
        de_q  <= 1'b1;
        vid_q <= vid_next;
      end
      if (ctl_take) begin
        de_q  <= 1'b0;
        ctl_q <= ctl_next;
      end
    end
  end
endmodule

// File: rtl/pwd_word_decoder.sv
module pwd_word_decoder #(
  parameter int TRIP_N = 5,
  parameter int RAW_N  = 4,
  localparam int WORD_W = 1 + 3*TRIP_N + RAW_N,
  localparam int VID_W  = WORD_W - 2,
  localparam int CTL_W  = TRIP_N + RAW_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic              word_is_video,
  input  logic [WORD_W-1:0] word_in,
  output logic              de_out,
  output logic [VID_W-1:0]  vid_out,
  output logic [CTL_W-1:0]  ctl_out,
  output logic              vote_err
);
  logic [TRIP_N-1:0][2:0] trip;
  logic [RAW_N-1:0]       raw;
  logic [VID_W-1:0]       sym;
  logic [VID_W-1:0]       vid_dec;
  logic [TRIP_N-1:0]      voted;
  logic                   word_split;
  logic                   vid_take;
  logic                   ctl_take;

  assign vid_take = word_vld &  word_is_video;
  assign ctl_take = word_vld & ~word_is_video;

  pwd_field_split #(.TRIP_N(TRIP_N), .RAW_N(RAW_N)) u_split (
    .word_i(word_in), .trip_o(trip), .raw_o(raw), .sym_o(sym)
  );

  pwd_triplet_voter #(.TRIP_N(TRIP_N)) u_vote (
    .trip_i(trip), .voted_o(voted), .any_split_o(word_split)
  );

  pwd_video_decode #(.VID_W(VID_W)) u_vdec (
    .sym_i(sym), .data_o(vid_dec)
  );

  pwd_out_regs #(.VID_W(VID_W), .CTL_W(CTL_W)) u_regs (
    .clk(clk), .rst(rst),
    .vid_take(vid_take), .ctl_take(ctl_take), .split_seen(word_split),
    .vid_next(vid_dec), .ctl_next({raw, voted}),
    .de_q(de_out), .vid_q(vid_out), .ctl_q(ctl_out), .err_q(vote_err)
  );
endmodule

// File: rtl/pwd_word_decoder_chk.sv
module pwd_word_decoder_chk #(
  parameter int TRIP_N = 5,
  parameter int RAW_N  = 4,
  localparam int WORD_W = 1 + 3*TRIP_N + RAW_N,
  localparam int VID_W  = WORD_W - 2,
  localparam int CTL_W  = TRIP_N + RAW_N
) (
  input logic              clk,
  input logic              rst,
  input logic              word_vld,
  input logic              word_is_video,
  input logic [WORD_W-1:0] word_in,
  input logic              de_out,
  input logic [VID_W-1:0]  vid_out,
  input logic [CTL_W-1:0]  ctl_out,
  input logic              vote_err
);
  always @(posedge clk) begin
    if ($past(rst)) begin
      p_reset_zero_r1: assert (!de_out && vid_out == '0 && ctl_out == '0 && !vote_err);
    end
  end

  p_video_field_r2: assert property (@(posedge clk) disable iff (rst)
    (word_vld && word_is_video) |=> (de_out && vid_out == $past(word_in[WORD_W-1:2])));

  p_raw_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !word_is_video) |=> (ctl_out[CTL_W-1 -: RAW_N] == $past(word_in[WORD_W-1 -: RAW_N])));

  p_ctl_de_low_r5: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !word_is_video) |=> !de_out);

  p_vid_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !word_is_video) |=> $stable(vid_out));

  p_ctl_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (word_vld && word_is_video) |=> $stable(ctl_out));

  p_err_source_r8: assert property (@(posedge clk) disable iff (rst)
    vote_err |-> $past(word_vld && !word_is_video));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !word_vld |=> ($stable(de_out) && $stable(vid_out) && $stable(ctl_out) && !vote_err));
endmodule

bind pwd_word_decoder pwd_word_decoder_chk #(.TRIP_N(TRIP_N), .RAW_N(RAW_N)) u_chk (
  .clk(clk), .rst(rst), .word_vld(word_vld), .word_is_video(word_is_video),
  .word_in(word_in), .de_out(de_out), .vid_out(vid_out), .ctl_out(ctl_out),
  .vote_err(vote_err)
);

// File: tb/pwd_word_decoder_tb.sv
module pwd_word_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_vld = 1'b0;
  logic        word_is_video = 1'b0;
  logic [19:0] word_in = '0;
  logic        de_out;
  logic [17:0] vid_out;
  logic [8:0]  ctl_out;
  logic        vote_err;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  logic        e_de = 1'b0;
  logic [17:0] e_vid = '0;
  logic [8:0]  e_ctl = '0;
  logic        e_err = 1'b0;

  always #2.5 clk = ~clk;

  pwd_word_decoder u_dut (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word_is_video(word_is_video),
    .word_in(word_in), .de_out(de_out), .vid_out(vid_out), .ctl_out(ctl_out),
    .vote_err(vote_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_cmp = n_cmp + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // control bits: C0..C4 voted by counting ones, C5..C8 raw
  function automatic logic [8:0] ref_ctl(input logic [19:0] w);
    logic [8:0] r;
    for (int i = 0; i < 5; i++) begin
      int ones;
      ones = 0;
      for (int k = 1; k <= 3; k++) ones += int'(w[3*i+k]);
      r[i] = (ones >= 2);
    end
    for (int j = 0; j < 4; j++) r[5+j] = w[16+j];
    return r;
  endfunction

  function automatic logic ref_split(input logic [19:0] w);
    logic s;
    s = 1'b0;
    for (int i = 0; i < 5; i++)
      if (!(w[3*i+1] == w[3*i+2] && w[3*i+2] == w[3*i+3])) s = 1'b1;
    return s;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp = n_cmp + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive on falling edge, one rising edge, compare on next falling edge
  task automatic step(input logic v, input logic isv, input logic [19:0] w);
    word_vld = v;
    word_is_video = isv;
    word_in = w;
    if (v && isv) begin
      e_de = 1'b1; e_vid = w[19:2]; e_err = 1'b0;
    end else if (v) begin
      e_de = 1'b0; e_ctl = ref_ctl(w); e_err = ref_split(w);
    end else begin
      e_err = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    if (v && isv) begin
      check("R2 de", 32'(de_out), 32'(e_de));
      check("R2 vid", 32'(vid_out), 32'(e_vid));
      check("R7 ctl hold", 32'(ctl_out), 32'(e_ctl));
    end else if (v) begin
      check("R5 de", 32'(de_out), 32'(e_de));
      check("R3/R4 ctl", 32'(ctl_out), 32'(e_ctl));
      check("R6 vid hold", 32'(vid_out), 32'(e_vid));
    end else begin
      check("R9 de hold", 32'(de_out), 32'(e_de));
      check("R9 vid hold", 32'(vid_out), 32'(e_vid));
      check("R9 ctl hold", 32'(ctl_out), 32'(e_ctl));
    end
    check("R8 err", 32'(vote_err), 32'(e_err));
  endtask

  initial begin
    logic [19:0] clean;
    void'($urandom(32'd5417));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 de", 32'(de_out), 32'd0);
    check("R1 vid", 32'(vid_out), 32'd0);
    check("R1 ctl", 32'(ctl_out), 32'd0);
    check("R1 err", 32'(vote_err), 32'd0);
    rst = 1'b0;

    // clean control word: C0..C4 = 1,0,1,1,0 ; C5..C8 = 1,0,0,1
    clean = {4'b1001, 3'b000, 3'b111, 3'b111, 3'b000, 3'b111, 1'b0};
    step(1'b1, 1'b0, clean);
    check("R3 clean value", 32'(ctl_out), 32'(9'b1001_01101));
    // single corrupted copy in every position of every triplet (R3, R8)
    for (int p = 1; p <= 15; p++) step(1'b1, 1'b0, clean ^ (20'd1 << p));
    // two copies flipped: vote flips, still flagged
    step(1'b1, 1'b0, clean ^ 20'h00006);
    // R10 overhead bit 0 in control word changes nothing
    step(1'b1, 1'b0, clean | 20'd1);
    check("R10 ctl", 32'(ctl_out), 32'(9'b1001_01101));
    // video words with both overhead patterns (R2, R10)
    step(1'b1, 1'b1, 20'hA5A53);
    step(1'b1, 1'b1, 20'hA5A50);
    check("R10 vid", 32'(vid_out), 32'(18'h29694));
    step(1'b1, 1'b1, 20'hFFFFC);
    // video word that would look like a split control word: no flag (R8)
    step(1'b1, 1'b1, 20'h00002);
    // idle cycles (R9)
    step(1'b0, 1'b0, 20'hFFFFF);
    step(1'b0, 1'b1, 20'h12345);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic v, isv;
      logic [19:0] w;
      v = ($urandom % 5) != 0;
      isv = $urandom % 2;
      w = 20'($urandom);
      if (!isv && ($urandom % 2)) begin
        for (int i = 0; i < 5; i++) begin
          logic b;
          b = $urandom % 2;
          w[3*i+1] = b; w[3*i+2] = b; w[3*i+3] = b;
        end
      end
      step(v, isv, w);
    end
    // reset in mid-run returns outputs to 0 (R1)
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 re-reset vid", 32'(vid_out), 32'd0);
    check("R1 re-reset ctl", 32'(ctl_out), 32'd0);
    check("R1 re-reset de", 32'(de_out), 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule